// File: doc/BRIEF.md
# GPIO Function-Select and Output Register File

This block is the register-mapped core of a general-purpose pin controller for up to 64 pins (58 by default). Each pin has a 3-bit function code. The code says whether the pin is a plain input, a driven output, or one of six alternate functions. The code goes straight to an external pin multiplexer, and the block also turns it into a per-pin output enable.

Output values live in a latch per pin. Software never writes that latch directly. It writes ones to a set window or to a clear window, so changing one pin needs no read-modify-write. Pin inputs pass through a small synchroniser and can be read back as level words. An identification word sits at a reserved address. It is non-zero only when the block is built for 54 pins, so software can tell the two sizes apart.

The bus is a simple single-cycle strobe interface with a word address. Read data is registered.

Top module: `gpio_regfile`

## Requirements
- R1: While reset is high and on the first cycle after it, every function code is 000 (input), every output latch is low, and every output enable is low.
- R2: Function words sit at word addresses 0 to 5. Pin p lives in word p/10 at bits (p%10)*3 +: 3. A write replaces every field in that word and reads back the same bits, with bits 30 and 31 reading zero. The code of pin p also appears on `pin_func[3p+2:3p]` from the cycle after the write.
- R3: `pin_oe[p]` is high exactly when pin p's code is 001. Code 000 and the six alternate codes (010 to 111) keep it low.
- R4: A write to a set word (address 8 for pins 0–31, address 9 for pins 32 and up) forces high every latch whose bit is 1. Bits that are 0 leave their latch unchanged.
- R5: A write to a clear word (address 10 for pins 0–31, address 11 for pins 32 and up) forces low every latch whose bit is 1. Bits that are 0 leave their latch unchanged.
- R6: Reads of addresses 8 to 11 return zero.
- R7: Level words (address 12 for pins 0–31, address 13 for pins 32 and up) return the pin inputs after a two-flop synchroniser. A read issued two cycles after an input change returns the new value. Bits with no pin read zero.
- R8: Address 15 returns 0x6770696f when the block is built with 54 pins and zero for any other size. Address 14 always reads zero.
- R9: `bus_rdata` is loaded on the clock edge where `bus_rd` is high and holds its value on cycles without a read.
- R10: `pin_out` always follows the output latch, whatever the pin's function code. A latch keeps its value while its pin is not an output.
- R11: Fields of a function word and bits of set or clear words that map to pins at or above the pin count are ignored and read back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output data (latch) |
| pin_func | output | 3*NUM_PINS | Per-pin function code for the external pin mux |

## Verification
Some behaviours are checked by the embedded assertions on every cycle:
- a set strobe really raises its latches and a clear strobe really lowers them;
- latches and output enables stay still when no relevant write occurs;
- read data holds between reads;
- the set and clear windows read zero;
- the unused high bits of the upper level word stay zero.

Other behaviours only show up in the bench's scenarios:
- the field packing of pin p into word p/10;
- the output enable depending only on code 001;
- the two-cycle latency from an input change to a visible level;
- the identification word appearing only in the 54-pin build.

Those scenarios compare against a bench model under random traffic and directed corner cases.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

    localparam int WORD_W        = 32;
    localparam int FUNC_W        = 3;
    localparam int PINS_PER_FSEL = 10;
    localparam int ADDR_W        = 4;
    localparam int ID_PIN_COUNT  = 54;
    localparam logic [WORD_W-1:0] ID_WORD = 32'h6770_696f;

    localparam logic [ADDR_W-1:0] A_SET_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_SET_HI = 4'd9;
    localparam logic [ADDR_W-1:0] A_CLR_LO = 4'd10;
    localparam logic [ADDR_W-1:0] A_CLR_HI = 4'd11;
    localparam logic [ADDR_W-1:0] A_LEV_LO = 4'd12;
    localparam logic [ADDR_W-1:0] A_LEV_HI = 4'd13;
    localparam logic [ADDR_W-1:0] A_ID     = 4'd15;

    typedef enum logic [FUNC_W-1:0] {
        FN_INPUT  = 3'b000,
        FN_OUTPUT = 3'b001,
        FN_ALT5   = 3'b010,
        FN_ALT4   = 3'b011,
        FN_ALT0   = 3'b100,
        FN_ALT1   = 3'b101,
        FN_ALT2   = 3'b110,
        FN_ALT3   = 3'b111
    } pin_func_e;

    typedef struct packed {
        logic       fsel;
        logic       set;
        logic       clr;
        logic       lev;
        logic       id;
        logic       hi;
        logic [2:0] idx;
    } reg_sel_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a, input int fsel_words);
        reg_sel_t s;
        s      = '0;
        s.idx  = a[2:0];
        s.hi   = a[0];
        s.fsel = (a[3] == 1'b0) && (int'(a[2:0]) < fsel_words);
        s.set  = (a == A_SET_LO) || (a == A_SET_HI);
        s.clr  = (a == A_CLR_LO) || (a == A_CLR_HI);
        s.lev  = (a == A_LEV_LO) || (a == A_LEV_HI);
        s.id   = (a == A_ID);
        return s;
    endfunction

endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
    import gpio_rf_pkg::*;
#(
    parameter int NUM_PINS = 58
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_idx,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [NUM_PINS*FUNC_W-1:0]         func_flat,
    output logic [NUM_PINS-1:0]                oe,
    output logic [ceil_div(NUM_PINS, PINS_PER_FSEL)*WORD_W-1:0] rd_flat
);
    localparam int NWORDS = ceil_div(NUM_PINS, PINS_PER_FSEL);

    pin_func_e func_q [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int W   = p / PINS_PER_FSEL;
        localparam int OFF = (p % PINS_PER_FSEL) * FUNC_W;

        always_ff @(posedge clk) begin
            if (rst)
                func_q[p] <= FN_INPUT;
            else if (wr_en && (int'(wr_idx) == W))
                func_q[p] <= pin_func_e'(wdata[OFF +: FUNC_W]);
        end

        assign func_flat[p*FUNC_W +: FUNC_W] = func_q[p];
        assign oe[p] = (func_q[p] == FN_OUTPUT);
    end

    always_comb begin
        rd_flat = '0;
        for (int p = 0; p < NUM_PINS; p++)
            rd_flat[(p / PINS_PER_FSEL)*WORD_W + (p % PINS_PER_FSEL)*FUNC_W +: FUNC_W] = func_q[p];
    end

    AST_OE_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(oe)); // R3

    AST_FSEL_RESET_INPUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (func_flat == '0) && (oe == '0)); // R1

    if (NWORDS > 8) begin : g_bad
        initial $error("gpio_fsel_bank: too many function words");
    end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int NUM_PINS = 58
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] set_mask,
    input  logic [NUM_PINS-1:0] clr_mask,
    output logic [NUM_PINS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_mask) & ~clr_mask;
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
        ((|set_mask) && !(|clr_mask)) |=> ((q & $past(set_mask)) == $past(set_mask))); // R4

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (|clr_mask) |=> ((q & $past(clr_mask)) == '0)); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(|set_mask) && !(|clr_mask)) |=> $stable(q)); // R10

    AST_LATCH_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == '0)); // R1
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 58,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] d,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_rf_pkg::*;
#(
    parameter int NUM_PINS    = 58,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [3:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]         pin_in,
    output logic [NUM_PINS-1:0]         pin_oe,
    output logic [NUM_PINS-1:0]         pin_out,
    output logic [NUM_PINS*3-1:0]       pin_func
);
    localparam int FSEL_WORDS = ceil_div(NUM_PINS, PINS_PER_FSEL);
    localparam int PAD_W      = 2 * WORD_W;

    reg_sel_t                     sel;
    logic [FSEL_WORDS*WORD_W-1:0] fsel_rd;
    logic [PAD_W-1:0]             set_full, clr_full, lev_full;
    logic [NUM_PINS-1:0]          lev_sync;
    logic [WORD_W-1:0]            id_value, rd_value;

    assign sel = decode(bus_addr, FSEL_WORDS);

    gpio_fsel_bank #(.NUM_PINS(NUM_PINS)) u_fsel (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr && sel.fsel),
        .wr_idx    (sel.idx),
        .wdata     (bus_wdata),
        .func_flat (pin_func),
        .oe        (pin_oe),
        .rd_flat   (fsel_rd)
    );

    always_comb begin
        set_full = '0;
        clr_full = '0;
        if (bus_wr && sel.set) set_full[(sel.hi ? WORD_W : 0) +: WORD_W] = bus_wdata;
        if (bus_wr && sel.clr) clr_full[(sel.hi ? WORD_W : 0) +: WORD_W] = bus_wdata;
    end

    gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_full[NUM_PINS-1:0]),
        .clr_mask (clr_full[NUM_PINS-1:0]),
        .q        (pin_out)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lev_sync)
    );

    always_comb begin
        lev_full = '0;
        lev_full[NUM_PINS-1:0] = lev_sync;
    end

    if (NUM_PINS == ID_PIN_COUNT) begin : g_id
        assign id_value = ID_WORD;
    end else begin : g_noid
        assign id_value = '0;
    end

    always_comb begin
        rd_value = '0;
        if (sel.fsel)     rd_value = fsel_rd[int'(sel.idx)*WORD_W +: WORD_W];
        else if (sel.lev) rd_value = lev_full[(sel.hi ? WORD_W : 0) +: WORD_W];
        else if (sel.id)  rd_value = id_value;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_value;
    end

    AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr >= A_SET_LO) && (bus_addr <= A_CLR_HI)) |=> (bus_rdata == '0)); // R6

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R9

    AST_LEVEL_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_LEV_HI)) |=> ((bus_rdata >> (NUM_PINS - WORD_W)) == '0)); // R7

    initial begin
        if (NUM_PINS <= WORD_W || NUM_PINS > PAD_W)
            $error("gpio_regfile: NUM_PINS must be 33..64");
    end
endmodule

// File: tb/tb_gpio_regfile.sv
module tb_gpio_regfile;
    localparam int NP = 58;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata, rdata54;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_oe, pin_out;
    logic [NP*3-1:0]   pin_func;
    logic [53:0]       oe54, out54;
    logic [54*3-1:0]   func54;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [2:0]  exp_func [NP];
    logic [63:0] exp_lat;

    always #5 clk = ~clk;

    gpio_regfile #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_func(pin_func));

    gpio_regfile #(.NUM_PINS(54)) dut54 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata54), .pin_in(pin_in[53:0]),
        .pin_oe(oe54), .pin_out(out54), .pin_func(func54));

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(1_000_000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=hung exp=done");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_fsel_word(input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 10; k++)
            if (w*10 + k < NP) r[k*3 +: 3] = exp_func[w*10 + k];
        return r;
    endfunction

    function automatic logic [63:0] exp_oe();
        logic [63:0] r = '0;
        for (int p = 0; p < NP; p++) r[p] = (exp_func[p] == 3'b001);
        return r;
    endfunction

    function automatic logic [NP*3-1:0] exp_funcs();
        logic [NP*3-1:0] r;
        for (int p = 0; p < NP; p++) r[p*3 +: 3] = exp_func[p];
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a <= 4'd5) begin
            for (int k = 0; k < 10; k++)
                if (int'(a)*10 + k < NP) exp_func[int'(a)*10 + k] = d[k*3 +: 3];
        end else if (a == 4'd8 || a == 4'd9) begin
            exp_lat = exp_lat | ({32'd0, d} << (a[0] ? 32 : 0));
        end else if (a == 4'd10 || a == 4'd11) begin
            exp_lat = exp_lat & ~({32'd0, d} << (a[0] ? 32 : 0));
        end
        exp_lat[63:NP] = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_pins(input string tag);
        chk({tag, " R3 pin_oe"}, 64'(pin_oe), exp_oe());
        chk({tag, " R10 pin_out"}, 64'(pin_out), exp_lat);
        n_chk++;
        if (pin_func !== exp_funcs()) begin
            n_fail++;
            $display("FAIL %s R2 pin_func act=%h exp=%h", tag, pin_func, exp_funcs());
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [63:0] lv;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) exp_func[p] = 3'b000;
        exp_lat = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 oe", 64'(pin_oe), 64'd0);
        chk("R1 out", 64'(pin_out), 64'd0);
        chk("R1 func", 64'(pin_func[63:0]), 64'd0);
        rd(4'd0, d); chk("R1 fsel0", 64'(d), 64'd0);

        // R2/R3 packing: pin3 output, pin0 alt code 100, pin12 output (word1 field 2)
        wr(4'd0, (32'd1 << 9) | 32'd4);
        wr(4'd1, (32'd1 << 6));
        chk_pins("dir1");
        chk("R3 pin3 oe", 64'(pin_oe[3]), 64'd1);
        chk("R3 pin0 alt oe", 64'(pin_oe[0]), 64'd0);
        chk("R2 pin12 code", 64'(pin_func[36 +: 3]), 64'd1);
        rd(4'd0, d); chk("R2 fsel0 readback", 64'(d), 64'h0000_0204);

        // R4/R5 set and clear, zero bits inert
        wr(4'd8, 32'h0000_0028);
        chk("R4 set pins 3,5", 64'(pin_out), 64'h28);
        wr(4'd8, 32'd0);
        chk("R4 zero set inert", 64'(pin_out), 64'h28);
        wr(4'd10, 32'd0);
        chk("R5 zero clear inert", 64'(pin_out), 64'h28);
        wr(4'd10, 32'h0000_0020);
        chk("R5 clear pin5", 64'(pin_out), 64'h08);
        chk("R10 pin5 latch low while input", 64'(pin_oe[5]), 64'd0);

        // R6 strobe windows read zero
        for (int a = 8; a <= 11; a++) begin
            rd(4'(a), d); chk("R6 strobe read zero", 64'(d), 64'd0);
        end

        // R11 absent fields and bits ignored
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, d); chk("R11 fsel5 upper fields", 64'(d), 64'h00FF_FFFF);
        chk_pins("alt111");
        wr(4'd9, 32'hFFFF_FFFF);
        chk("R11 set hi masked", 64'(pin_out), exp_lat);
        chk("R11 top bits", 64'(pin_out[57:32]), 64'h3FF_FFFF);

        // R7 synchronised level
        pin_in = 58'h2AB_CDEF_0123_4567;
        @(negedge clk); @(negedge clk);
        rd(4'd12, d); chk("R7 level lo", 64'(d), 64'h0123_4567);
        rd(4'd13, d); chk("R7 level hi", 64'(d), 64'h02AB_CDEF);
        pin_in = '1;
        rd(4'd12, d); chk("R7 not yet visible", 64'(d), 64'h0123_4567);

        // R8 identification word
        rd(4'd15, d);
        chk("R8 id 58 pins", 64'(d), 64'd0);
        chk("R8 id 54 pins", 64'(rdata54), 64'h6770_696f);
        rd(4'd14, d); chk("R8 addr14 zero", 64'(d), 64'd0);

        // R9 hold without read
        rd(4'd1, d);
        bus_addr = 4'd15;
        @(negedge clk); @(negedge clk);
        chk("R9 rdata holds", 64'(bus_rdata), 64'(exp_fsel_word(1)));

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 5;
            case (op)
                0: wr(4'($urandom % 6), $urandom);
                1: wr(4'(8 + ($urandom % 2)), $urandom & $urandom);
                2: wr(4'(10 + ($urandom % 2)), $urandom & $urandom);
                3: begin
                    lv = {$urandom, $urandom};
                    pin_in = lv[NP-1:0];
                    @(negedge clk); @(negedge clk);
                    rd(4'd13, d); chk("R7 random hi", 64'(d), 64'(lv[NP-1:32]));
                end
                default: begin
                    int w = $urandom % 6;
                    rd(4'(w), d); chk("R2 random fsel", 64'(d), 64'(exp_fsel_word(w)));
                end
            endcase
            chk_pins("rand");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule